// File: doc/BRIEF.md
# Instruction-Driven 4-Bit Port Controller

This block turns the port instructions of a small controller core into pin activity across eight numbered 4-bit ports. Each instruction arrives as one strobe carrying an operation code, a port number and a 4-bit data or mask field. Six operations act on the addressed port: read it, write its latch, set the masked bits, clear the masked bits, skip if every masked bit is 1, and skip if every masked bit is 0. A seventh operation loads the per-bit direction latch of the bit-direction port. The read result and the skip flag are registered, so they are valid in the cycle after the instruction.

The ports come in several kinds. Three are plain push-pull outputs. One is an open-drain sink. Two are input-only. One is a sticky-direction port that has no direction register: every read or test makes it an input, and every write, set or clear makes it an output. It stays that way until an instruction of the other kind reaches it. One port takes its direction bit by bit from a separate latch. A backup input puts all ports in a low-power state: no pin is driven and every input reads as zero. All latches and directions keep their values through backup.

Operation codes: 0 read, 1 write, 2 set bits, 3 clear bits, 4 skip-if-all-ones, 5 skip-if-all-zeros, 6 load bit-direction latch, 7 no operation. Port numbers: 0 key input, 1 output port one, 2 output port two, 3 output port three, 4 sticky-direction port, 5 bit-direction port, 6 auxiliary input, 7 open-drain sink port. Numbers 8 to 15 are not implemented.

Top module: `ioport_top`

## Requirements
- R1: After reset the three output ports drive value 0 with all enables high, the sink port has every sink off, the sticky and bit-direction ports have every enable low, and rdData and skip are 0.
- R2: A write (code 1) to ports 1, 2, 3 or 7 loads opData into that port's latch. A later read (code 0) returns the latch value on rdData in the cycle after the read instruction. The output ports drive the latch value on their pins.
- R3: Set bits (code 2) ORs the mask into the addressed latch, and clear bits (code 3) clears the masked bits. Bits outside the mask keep their values.
- R4: Code 4 raises skip for one cycle when every masked bit of the port's read value is 1. Code 5 raises skip when every masked bit is 0. An empty mask always skips. Skip is 0 after any other instruction or idle cycle, and tests leave rdData unchanged.
- R5: The sticky port (4) becomes an input (all enables low) after a read or either test. It becomes an output (all enables high, driving its latch) after a write, set or clear. The direction holds until an instruction of the opposite kind reaches that port.
- R6: A read or test of the sticky port uses its pin samples, not its latch.
- R7: Code 6 loads opData into the bit-direction latch, whatever the port field holds; 1 means output. Port 5 enables exactly those bits. When port 5 is read, output bits return the latch and input bits return the pins.
- R8: Ports 0 and 6 read their pins. Writes, sets and clears aimed at them have no visible effect.
- R9: While backup is high, all output enables and sink controls are 0, and pin-sourced bits read as 0. When backup falls, all latches and directions are as before.
- R10: Port numbers 8 to 15 read as 0, and any instruction to them leaves every latch and direction unchanged.
- R11: The sink port pulls pin bit i low exactly when its latch bit i is 1. It is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| backup | input | 1 | Low-power state: outputs released, inputs read 0 |
| opValid | input | 1 | Instruction strobe |
| opCode | input | 3 | Operation code |
| portSel | input | 4 | Port number |
| opData | input | 4 | Write data or bit mask |
| rdData | output | 4 | Result of the last read instruction |
| skip | output | 1 | Test result, valid one cycle after a test |
| keyIn | input | 4 | Port 0 pins |
| auxIn | input | 4 | Port 6 pins |
| out1Val | output | 4 | Port 1 pin value |
| out1Oe | output | 4 | Port 1 enables |
| out2Val | output | 4 | Port 2 pin value |
| out2Oe | output | 4 | Port 2 enables |
| out3Val | output | 4 | Port 3 pin value |
| out3Oe | output | 4 | Port 3 enables |
| stkVal | output | 4 | Port 4 drive value |
| stkOe | output | 4 | Port 4 enables |
| stkIn | input | 4 | Port 4 pin samples |
| bdVal | output | 4 | Port 5 drive value |
| bdOe | output | 4 | Port 5 per-bit enables |
| bdIn | input | 4 | Port 5 pin samples |
| sinkOn | output | 4 | Port 7 pull-low controls |

## Verification
A walk through a vector table drives writes, sets and clears into the latch ports and then reads each one back. A pattern that keeps some bits and flips others shows whether the mask logic touches only the selected bits. Tests use masks that hit all-ones, all-zeros and mixed bit groups, so an inverted or swapped skip condition fails. Writes aimed at input-only and unimplemented ports are each followed by a read, which shows they had no effect. Directed sequences move the sticky port back and forth between its two kinds of instruction, take the bit-direction port through a mixed mask, and enter and leave backup, to show that nothing is driven and nothing is lost.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int NPORT = 8;
  localparam int SEL_W = 4;

  localparam int IDX_KEY  = 0;
  localparam int IDX_OUT1 = 1;
  localparam int IDX_OUT2 = 2;
  localparam int IDX_OUT3 = 3;
  localparam int IDX_STK  = 4;
  localparam int IDX_BD   = 5;
  localparam int IDX_AUX  = 6;
  localparam int IDX_SINK = 7;

  // ports whose latch an instruction may change
  localparam logic [NPORT-1:0] WR_MASK = 8'b1011_1110;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SETB  = 3'd2,
    OP_CLRB  = 3'd3,
    OP_TONES = 3'd4,
    OP_TZERO = 3'd5,
    OP_DIRBD = 3'd6,
    OP_IDLE  = 3'd7
  } portOp_e;

  typedef struct packed {
    logic [NPORT-1:0] selOh;
    logic wrAll;
    logic wrSet;
    logic wrClr;
    logic ldDir;
    logic stkToIn;
    logic stkToOut;
  } portStrobe_t;
endpackage

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
  import ioport_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [SEL_W-1:0] portSel,
  input  logic [DW-1:0]    opData,
  input  logic [DW-1:0]    readVal,
  output portStrobe_t      strobe,
  output logic [DW-1:0]    rdData,
  output logic             skip
);
  localparam int IDX_W = $clog2(NPORT);

  portOp_e op;
  logic    implPort;
  logic    isTest;
  logic    allOnes;
  logic    allZeros;

  assign op       = portOp_e'(opCode);
  assign implPort = (int'(portSel) < NPORT);
  assign isTest   = opValid && (op == OP_TONES || op == OP_TZERO);
  assign allOnes  = ((readVal & opData) == opData);
  assign allZeros = ((readVal & opData) == '0);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      if (implPort) strobe.selOh[portSel[IDX_W-1:0]] = 1'b1;
      strobe.wrAll = (op == OP_WRITE);
      strobe.wrSet = (op == OP_SETB);
      strobe.wrClr = (op == OP_CLRB);
      strobe.ldDir = (op == OP_DIRBD);
      if (int'(portSel) == IDX_STK) begin
        strobe.stkToIn  = (op == OP_READ) || (op == OP_TONES) || (op == OP_TZERO);
        strobe.stkToOut = (op == OP_WRITE) || (op == OP_SETB) || (op == OP_CLRB);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      skip   <= 1'b0;
    end else begin
      if (opValid && op == OP_READ) rdData <= readVal;
      skip <= isTest && ((op == OP_TONES) ? allOnes : allZeros);
    end
  end

  // R4: skip only follows a test instruction
  assert_skip_needs_test_R4: assert property (@(posedge clk) disable iff (!rstN)
    !isTest |=> !skip);

  // R4: tests leave the read result untouched
  assert_test_keeps_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    isTest |=> $stable(rdData));
endmodule

// File: rtl/ioport_dp.sv
module ioport_dp
  import ioport_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             backup,
  input  portStrobe_t      strobe,
  input  logic [SEL_W-1:0] portSel,
  input  logic [DW-1:0]    opData,
  input  logic [DW-1:0]    keyIn,
  input  logic [DW-1:0]    auxIn,
  input  logic [DW-1:0]    stkIn,
  input  logic [DW-1:0]    bdIn,
  output logic [DW-1:0]    readVal,
  output logic [DW-1:0]    out1Val,
  output logic [DW-1:0]    out1Oe,
  output logic [DW-1:0]    out2Val,
  output logic [DW-1:0]    out2Oe,
  output logic [DW-1:0]    out3Val,
  output logic [DW-1:0]    out3Oe,
  output logic [DW-1:0]    stkVal,
  output logic [DW-1:0]    stkOe,
  output logic [DW-1:0]    bdVal,
  output logic [DW-1:0]    bdOe,
  output logic [DW-1:0]    sinkOn
);
  localparam int IDX_W = $clog2(NPORT);

  logic [DW-1:0] latQ [NPORT];
  logic          stkIsOut;
  logic [DW-1:0] bdDir;
  logic [DW-1:0] inGate;
  logic [DW-1:0] bdView;
  logic [DW-1:0] viewV [NPORT];

  assign inGate = {DW{~backup}};

  // latches of writable ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPORT; i++) latQ[i] <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (WR_MASK[i] && strobe.selOh[i]) begin
          if (strobe.wrAll)      latQ[i] <= opData;
          else if (strobe.wrSet) latQ[i] <= latQ[i] | opData;
          else if (strobe.wrClr) latQ[i] <= latQ[i] & ~opData;
        end
      end
    end
  end

  // sticky direction and bit direction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stkIsOut <= 1'b0;
      bdDir    <= '0;
    end else begin
      if (strobe.stkToIn)       stkIsOut <= 1'b0;
      else if (strobe.stkToOut) stkIsOut <= 1'b1;
      if (strobe.ldDir) bdDir <= opData;
    end
  end

  // per-bit source for the bit-direction port
  for (genvar b = 0; b < DW; b++) begin : gBdBit
    assign bdView[b] = bdDir[b] ? latQ[IDX_BD][b] : bdIn[b];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) viewV[i] = latQ[i];
    viewV[IDX_KEY] = keyIn & inGate;
    viewV[IDX_AUX] = auxIn & inGate;
    viewV[IDX_STK] = stkIn & inGate;
    viewV[IDX_BD]  = bdView & inGate;
  end

  assign readVal = (int'(portSel) < NPORT) ? viewV[portSel[IDX_W-1:0]] : '0;

  assign out1Val = latQ[IDX_OUT1];
  assign out2Val = latQ[IDX_OUT2];
  assign out3Val = latQ[IDX_OUT3];
  assign out1Oe  = inGate;
  assign out2Oe  = inGate;
  assign out3Oe  = inGate;
  assign stkVal  = latQ[IDX_STK];
  assign stkOe   = {DW{stkIsOut}} & inGate;
  assign bdVal   = latQ[IDX_BD];
  assign bdOe    = bdDir & inGate;
  assign sinkOn  = latQ[IDX_SINK] & inGate;

  // R5: reads and tests turn the sticky port into an input
  assert_stk_to_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stkToIn |=> !stkIsOut);
  // R5: writes turn it into an output
  assert_stk_to_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stkToOut && !strobe.stkToIn) |=> stkIsOut);
  // R5: direction holds without a sticky-port instruction
  assert_stk_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stkToIn || strobe.stkToOut) |=> $stable(stkIsOut));
  // R7: the direction latch takes the instruction data
  assert_dir_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldDir |=> (bdDir == $past(opData)));
  // R10: with no port selected no latch moves
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selOh == '0) |=>
      $stable({latQ[IDX_OUT1], latQ[IDX_OUT2], latQ[IDX_OUT3],
               latQ[IDX_STK], latQ[IDX_BD], latQ[IDX_SINK]}));
  // R9: backup releases every driver
  assert_backup_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    backup |-> (sinkOn == '0 && stkOe == '0 && bdOe == '0 && out1Oe == '0));
endmodule

// File: rtl/ioport_top.sv
module ioport_top
  import ioport_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             backup,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [SEL_W-1:0] portSel,
  input  logic [DW-1:0]    opData,
  output logic [DW-1:0]    rdData,
  output logic             skip,
  input  logic [DW-1:0]    keyIn,
  input  logic [DW-1:0]    auxIn,
  output logic [DW-1:0]    out1Val,
  output logic [DW-1:0]    out1Oe,
  output logic [DW-1:0]    out2Val,
  output logic [DW-1:0]    out2Oe,
  output logic [DW-1:0]    out3Val,
  output logic [DW-1:0]    out3Oe,
  output logic [DW-1:0]    stkVal,
  output logic [DW-1:0]    stkOe,
  input  logic [DW-1:0]    stkIn,
  output logic [DW-1:0]    bdVal,
  output logic [DW-1:0]    bdOe,
  input  logic [DW-1:0]    bdIn,
  output logic [DW-1:0]    sinkOn
);
  portStrobe_t   strobe;
  logic [DW-1:0] readVal;

  ioport_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .portSel(portSel), .opData(opData), .readVal(readVal),
    .strobe(strobe), .rdData(rdData), .skip(skip)
  );

  ioport_dp #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .backup(backup), .strobe(strobe),
    .portSel(portSel), .opData(opData), .keyIn(keyIn), .auxIn(auxIn),
    .stkIn(stkIn), .bdIn(bdIn), .readVal(readVal),
    .out1Val(out1Val), .out1Oe(out1Oe), .out2Val(out2Val), .out2Oe(out2Oe),
    .out3Val(out3Val), .out3Oe(out3Oe), .stkVal(stkVal), .stkOe(stkOe),
    .bdVal(bdVal), .bdOe(bdOe), .sinkOn(sinkOn)
  );
endmodule

// File: tb/ioport_top_test.sv
`timescale 1ns/1ps
module ioport_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       backup = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = 3'd7;
  logic [3:0] portSel = '0;
  logic [3:0] opData = '0;
  logic [3:0] keyIn = 4'hA, auxIn = 4'h5, stkIn = 4'h6, bdIn = 4'h9;
  logic [3:0] rdData, out1Val, out1Oe, out2Val, out2Oe, out3Val, out3Oe;
  logic [3:0] stkVal, stkOe, bdVal, bdOe, sinkOn;
  logic       skip;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ioport_top uut (
    .clk(clk), .rstN(rstN), .backup(backup), .opValid(opValid),
    .opCode(opCode), .portSel(portSel), .opData(opData),
    .rdData(rdData), .skip(skip), .keyIn(keyIn), .auxIn(auxIn),
    .out1Val(out1Val), .out1Oe(out1Oe), .out2Val(out2Val), .out2Oe(out2Oe),
    .out3Val(out3Val), .out3Oe(out3Oe), .stkVal(stkVal), .stkOe(stkOe),
    .stkIn(stkIn), .bdVal(bdVal), .bdOe(bdOe), .bdIn(bdIn), .sinkOn(sinkOn)
  );

  // {op[3], port[4], data[4], chkRd[1], expRd[4], expSkip[1]}
  localparam int NV = 30;
  localparam logic [16:0] VEC [NV] = '{
    {3'd1, 4'd1, 4'h5, 1'b0, 4'h0, 1'b0},   // R2 write port 1
    {3'd0, 4'd1, 4'h0, 1'b1, 4'h5, 1'b0},   // R2 read back
    {3'd2, 4'd1, 4'h8, 1'b0, 4'h0, 1'b0},   // R3 set bit 3
    {3'd0, 4'd1, 4'h0, 1'b1, 4'hD, 1'b0},
    {3'd3, 4'd1, 4'h1, 1'b0, 4'h0, 1'b0},   // R3 clear bit 0
    {3'd0, 4'd1, 4'h0, 1'b1, 4'hC, 1'b0},
    {3'd4, 4'd1, 4'hC, 1'b0, 4'h0, 1'b1},   // R4 all ones
    {3'd4, 4'd1, 4'hE, 1'b0, 4'h0, 1'b0},   // R4 one bit zero
    {3'd5, 4'd1, 4'h3, 1'b0, 4'h0, 1'b1},   // R4 all zeros
    {3'd5, 4'd1, 4'h4, 1'b0, 4'h0, 1'b0},   // R4 one bit set
    {3'd4, 4'd1, 4'h0, 1'b0, 4'h0, 1'b1},   // R4 empty mask
    {3'd0, 4'd0, 4'h0, 1'b1, 4'hA, 1'b0},   // R8 key pins
    {3'd1, 4'd0, 4'hF, 1'b0, 4'h0, 1'b0},   // R8 write ignored
    {3'd0, 4'd0, 4'h0, 1'b1, 4'hA, 1'b0},
    {3'd2, 4'd6, 4'hF, 1'b0, 4'h0, 1'b0},   // R8 set ignored
    {3'd0, 4'd6, 4'h0, 1'b1, 4'h5, 1'b0},
    {3'd1, 4'd7, 4'h3, 1'b0, 4'h0, 1'b0},   // R11 sink latch
    {3'd0, 4'd7, 4'h0, 1'b1, 4'h3, 1'b0},
    {3'd0, 4'd9, 4'h0, 1'b1, 4'h0, 1'b0},   // R10 unimplemented read
    {3'd1, 4'd9, 4'hF, 1'b0, 4'h0, 1'b0},   // R10 write ignored
    {3'd4, 4'd9, 4'h1, 1'b0, 4'h0, 1'b0},
    {3'd5, 4'd15, 4'hF, 1'b0, 4'h0, 1'b1},
    {3'd6, 4'd0, 4'h3, 1'b0, 4'h0, 1'b0},   // R7 low bits output
    {3'd1, 4'd5, 4'h6, 1'b0, 4'h0, 1'b0},
    {3'd0, 4'd5, 4'h0, 1'b1, 4'hA, 1'b0},   // R7 mixed view
    {3'd4, 4'd5, 4'h3, 1'b0, 4'h0, 1'b0},
    {3'd1, 4'd2, 4'h7, 1'b0, 4'h0, 1'b0},
    {3'd0, 4'd2, 4'h0, 1'b1, 4'h7, 1'b0},   // R2 port 2
    {3'd1, 4'd3, 4'h9, 1'b0, 4'h0, 1'b0},
    {3'd0, 4'd3, 4'h0, 1'b1, 4'h9, 1'b0}    // R2 port 3
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [3:0] p, input logic [3:0] d);
    @(negedge clk);
    opValid = 1'b1; opCode = op; portSel = p; opData = d;
    @(negedge clk);
    opValid = 1'b0; opCode = 3'd7;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out1Val", out1Val, 4'h0);
    chk("R1 out1Oe", out1Oe, 4'hF);
    chk("R1 out3Oe", out3Oe, 4'hF);
    chk("R1 stkOe", stkOe, 4'h0);
    chk("R1 bdOe", bdOe, 4'h0);
    chk("R1 sinkOn", sinkOn, 4'h0);
    chk("R1 rdData", rdData, 4'h0);
    chk("R1 skip", {3'b0, skip}, 4'h0);

    for (int v = 0; v < NV; v++) begin
      doOp(VEC[v][16:14], VEC[v][13:10], VEC[v][9:6]);
      chk($sformatf("R4 skip vector %0d", v), {3'b0, skip}, {3'b0, VEC[v][0]});
      if (VEC[v][5]) chk($sformatf("R2 rdData vector %0d", v), rdData, VEC[v][4:1]);
    end

    // R2 pins follow latches, R11 sink follows latch
    chk("R2 out1Val pin", out1Val, 4'hC);
    chk("R2 out3Val pin", out3Val, 4'h9);
    chk("R11 sinkOn", sinkOn, 4'h3);
    chk("R7 bdOe", bdOe, 4'h3);
    chk("R7 bdVal", bdVal, 4'h6);
    chk("R4 idle skip", {3'b0, skip}, 4'h0);

    // R5/R6 sticky direction
    chk("R5 initial input", stkOe, 4'h0);
    doOp(3'd1, 4'd4, 4'h3);
    chk("R5 write -> output", stkOe, 4'hF);
    chk("R5 drive value", stkVal, 4'h3);
    doOp(3'd5, 4'd4, 4'h0);
    chk("R5 test -> input", stkOe, 4'h0);
    doOp(3'd2, 4'd4, 4'h4);
    chk("R5 set -> output", stkOe, 4'hF);
    chk("R3 sticky set", stkVal, 4'h7);
    doOp(3'd1, 4'd1, 4'h2);
    chk("R5 other port keeps output", stkOe, 4'hF);
    doOp(3'd0, 4'd4, 4'h0);
    chk("R6 read pins", rdData, 4'h6);
    chk("R5 read -> input", stkOe, 4'h0);
    doOp(3'd0, 4'd4, 4'h0);
    chk("R5 stays input", stkOe, 4'h0);
    doOp(3'd4, 4'd4, 4'h6);
    chk("R6 test uses pins", {3'b0, skip}, 4'h1);
    doOp(3'd3, 4'd4, 4'h1);
    chk("R5 clear -> output", stkOe, 4'hF);
    chk("R3 sticky clear", stkVal, 4'h6);

    // R9 backup
    @(negedge clk);
    backup = 1'b1;
    #1;
    chk("R9 out1Oe", out1Oe, 4'h0);
    chk("R9 out2Oe", out2Oe, 4'h0);
    chk("R9 stkOe", stkOe, 4'h0);
    chk("R9 bdOe", bdOe, 4'h0);
    chk("R9 sinkOn", sinkOn, 4'h0);
    doOp(3'd0, 4'd0, 4'h0);
    chk("R9 key reads 0", rdData, 4'h0);
    doOp(3'd0, 4'd5, 4'h0);
    chk("R9 bit-dir port reads 0", rdData, 4'h0);
    backup = 1'b0;
    #1;
    chk("R9 out1 kept", out1Val, 4'h2);
    chk("R9 out1Oe back", out1Oe, 4'hF);
    chk("R9 sink kept", sinkOn, 4'h3);
    chk("R9 sticky dir kept", stkOe, 4'hF);
    chk("R9 bd dir kept", bdOe, 4'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule